// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block lets a host processor reach the configuration space of devices on an expansion bus through two memory-mapped words. The first is a command register. It holds a go flag and the bus, device, function and dword register number of the target. The second is a data window. A host read or write of the data window, made while the go flag is set, starts exactly one configuration transaction on a request/response interface toward the bus engine. The host access is stalled until that transaction completes.

Sub-word writes reach only the byte lanes that the host enables, and those byte enables are passed on to the target unchanged. Reads always fetch the whole dword. Software picks out a byte or halfword by shifting the dword right by eight times the low offset bits. An access to the data window with the go flag clear, or to any unrelated offset, completes locally and never reaches the bus. A target that does not answer within a parameterised number of cycles ends the access with an error flag.

Top module: `cfg_access_port`

## Requirements
- R1: The command register sits at byte offset 0x28. Its fields are: go flag at bit 31, bus at bits 23:16, device at bits 15:11, function at bits 10:8, dword register number at bits 7:2. Bits 30:24 and 1:0 always read as zero. Each host byte enable updates its own byte of the register.
- R2: An access to the data window at byte offset 0x2C (any low offset 0x2C..0x2F) with the go flag set issues exactly one configuration request. That request carries the bus, device, function and dword number held in the command register.
- R3: On a configuration write, the target receives the host byte enables and write data unchanged, so only the enabled lanes of the target dword change.
- R4: On a configuration read, the request byte enables are all ones and the full dword is returned. Byte k (k = offset & 3) is bits 8k+7:8k of the returned value.
- R5: A data-window access with the go flag clear issues no configuration request, completes with error low, and returns 0xFFFFFFFF on a read.
- R6: The host access stays stalled (host_ready low) until the configuration response arrives. The request fields stay stable while it waits, and host_ready is a single-cycle pulse.
- R7: If no response comes within TIMEOUT cycles of the request, the request is withdrawn and the access completes with host_err high and 0xFFFFFFFF as read data.
- R8: Offsets other than the command register and the data window read as zero, ignore writes and issue no configuration request.
- R9: After reset, no request is pending, host_ready is low and the command register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address within the register block |
| host_be | input | 4 | Host byte enables, data on natural lanes |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_err | output | 1 | Timeout indication, valid with host_ready |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_dev | output | 5 | Target device number |
| cfg_req_fn | output | 3 | Target function number |
| cfg_req_dreg | output | 6 | Target dword register number |
| cfg_req_be | output | 4 | Target byte enables |
| cfg_req_wdata | output | 32 | Target write data |
| cfg_rsp_valid | input | 1 | Target response strobe |
| cfg_rsp_rdata | input | 32 | Target read data |

## Verification
The assertions watch, on every cycle, the rules that hold at all times. A request only begins while the go flag is set and carries full byte enables when it is a read. It holds its fields until it is answered or withdrawn. The ready pulse lasts one cycle, an error completion always carries all-ones data, and no unrelated offset ever has a request in flight. Only the bench's scenarios can show the actual data paths: lane merging in the target dword, the field values that reach the target, the local data of a disabled access, and the stall length under a slow target or a silent one.

// File: rtl/cfgport_pkg.sv
`timescale 1ns/1ps
package cfgport_pkg;

  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;

  // command word layout; the bit positions are decoded by software
  typedef struct packed {
    logic       go;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dreg;
    logic [1:0] pad;
  } cfg_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } xact_state_t;

  // expand per-lane enables into a bit mask
  function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] merge_lanes(input logic [WORD_W-1:0] old_w,
                                                    input logic [WORD_W-1:0] new_w,
                                                    input logic [LANES-1:0]  be);
    logic [WORD_W-1:0] m;
    m = lane_mask(be);
    return (old_w & ~m) | (new_w & m);
  endfunction

  // force the reserved and sub-dword bits to zero
  function automatic cfg_cmd_t clean_cmd(input logic [WORD_W-1:0] raw);
    cfg_cmd_t c;
    c      = cfg_cmd_t'(raw);
    c.rsvd = '0;
    c.pad  = '0;
    return c;
  endfunction

endpackage

// File: rtl/cfgport_cmd_reg.sv
`timescale 1ns/1ps
module cfgport_cmd_reg
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wr_data,
  output cfg_cmd_t          cmd_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (wr_en) cmd_q <= clean_cmd(merge_lanes(WORD_W'(cmd_q), wr_data, wr_be));
  end

  // R1: the command word changes only on a host write to it
  assert_cmd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmd_q));

endmodule

// File: rtl/cfgport_xact.sv
`timescale 1ns/1ps
module cfgport_xact
  import cfgport_pkg::*;
#(
  parameter int TIMEOUT = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  output logic              idle,
  input  logic              start_xact,
  input  logic              start_local,
  input  logic [WORD_W-1:0] local_rdata,
  input  logic              x_write,
  input  cfg_cmd_t          x_cmd,
  input  logic [LANES-1:0]  x_be,
  input  logic [WORD_W-1:0] x_wdata,
  output logic              cfg_req_valid,
  output logic              cfg_req_write,
  output logic [7:0]        cfg_req_bus,
  output logic [4:0]        cfg_req_dev,
  output logic [2:0]        cfg_req_fn,
  output logic [5:0]        cfg_req_dreg,
  output logic [LANES-1:0]  cfg_req_be,
  output logic [WORD_W-1:0] cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [WORD_W-1:0] cfg_rsp_rdata,
  output logic              host_ready,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_err
);

  localparam int               CNT_W    = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  xact_state_t       state_q;
  logic [CNT_W-1:0]  tmo_cnt;
  cfg_cmd_t          tgt_q;
  logic              write_q;
  logic [LANES-1:0]  be_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q;
  logic              err_q;

  // named events for the checks
  logic rsp_hit, tmo_hit;
  assign rsp_hit = (state_q == ST_WAIT) && cfg_rsp_valid;
  assign tmo_hit = (state_q == ST_WAIT) && !cfg_rsp_valid && (tmo_cnt == CNT_LAST);
  assign idle    = (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmo_cnt <= '0;
      tgt_q   <= '0;
      write_q <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_xact) begin
            tgt_q   <= x_cmd;
            write_q <= x_write;
            be_q    <= x_write ? x_be : '1;
            wdata_q <= x_wdata;
            tmo_cnt <= '0;
            state_q <= ST_WAIT;
          end else if (start_local) begin
            rdata_q <= local_rdata;
            err_q   <= 1'b0;
            state_q <= ST_RESP;
          end
        end
        ST_WAIT: begin
          if (rsp_hit) begin
            rdata_q <= write_q ? '0 : cfg_rsp_rdata;
            err_q   <= 1'b0;
            state_q <= ST_RESP;
          end else if (tmo_hit) begin
            rdata_q <= '1;
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_req_valid = (state_q == ST_WAIT);
  assign cfg_req_write = write_q;
  assign cfg_req_bus   = tgt_q.bus;
  assign cfg_req_dev   = tgt_q.dev;
  assign cfg_req_fn    = tgt_q.fn;
  assign cfg_req_dreg  = tgt_q.dreg;
  assign cfg_req_be    = be_q;
  assign cfg_req_wdata = wdata_q;
  assign host_ready    = (state_q == ST_RESP);
  assign host_rdata    = rdata_q;
  assign host_err      = err_q;

  // R4: reads always fetch the whole dword
  assert_read_full_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_write) |-> (cfg_req_be == '1));

  // R6: an unanswered request holds its fields
  assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_rsp_valid && !tmo_hit) |=>
      (cfg_req_valid && $stable(cfg_req_bus) && $stable(cfg_req_dev) &&
       $stable(cfg_req_fn) && $stable(cfg_req_dreg) && $stable(cfg_req_be) &&
       $stable(cfg_req_wdata) && $stable(cfg_req_write)));

  // R6: completion is a single-cycle pulse
  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  // R7: an error completion carries all-ones data and follows a timeout
  assert_err_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && host_err) |-> (host_rdata == '1));
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && host_err) |-> $past(tmo_hit));
  assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (tmo_cnt <= CNT_LAST));

endmodule

// File: rtl/cfg_access_port.sv
`timescale 1ns/1ps
module cfg_access_port
  import cfgport_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = ADDR_W'(8'h28),
  parameter int              TIMEOUT    = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  output logic              host_ready,
  output logic [31:0]       host_rdata,
  output logic              host_err,
  output logic              cfg_req_valid,
  output logic              cfg_req_write,
  output logic [7:0]        cfg_req_bus,
  output logic [4:0]        cfg_req_dev,
  output logic [2:0]        cfg_req_fn,
  output logic [5:0]        cfg_req_dreg,
  output logic [3:0]        cfg_req_be,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [31:0]       cfg_rsp_rdata
);

  localparam logic [ADDR_W-1:0] DATA_OFFSET = CMD_OFFSET + ADDR_W'(4);
  localparam int                WA_W        = ADDR_W - 2;

  cfg_cmd_t          cmd_q;
  logic              idle;
  logic              hit_cmd, hit_data, accept;
  logic              cmd_wr, start_xact, start_local;
  logic [WORD_W-1:0] local_rdata;

  // word-granular decode; low bits select lanes only
  assign hit_cmd  = (host_addr[ADDR_W-1:2] == CMD_OFFSET[ADDR_W-1:2]);
  assign hit_data = (host_addr[ADDR_W-1:2] == DATA_OFFSET[ADDR_W-1:2]);
  assign accept   = host_valid && idle;

  assign cmd_wr      = accept && host_write && hit_cmd;
  assign start_xact  = accept && hit_data && cmd_q.go;
  assign start_local = accept && !(hit_data && cmd_q.go);

  always_comb begin
    if (host_write)    local_rdata = '0;
    else if (hit_cmd)  local_rdata = WORD_W'(cmd_q);
    else if (hit_data) local_rdata = '1;
    else               local_rdata = '0;
  end

  cfgport_cmd_reg i_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd_wr),
    .wr_be   (host_be),
    .wr_data (host_wdata),
    .cmd_q   (cmd_q)
  );

  cfgport_xact #(.TIMEOUT(TIMEOUT)) i_xact (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle          (idle),
    .start_xact    (start_xact),
    .start_local   (start_local),
    .local_rdata   (local_rdata),
    .x_write       (host_write),
    .x_cmd         (cmd_q),
    .x_be          (host_be),
    .x_wdata       (host_wdata),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_write (cfg_req_write),
    .cfg_req_bus   (cfg_req_bus),
    .cfg_req_dev   (cfg_req_dev),
    .cfg_req_fn    (cfg_req_fn),
    .cfg_req_dreg  (cfg_req_dreg),
    .cfg_req_be    (cfg_req_be),
    .cfg_req_wdata (cfg_req_wdata),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_rdata (cfg_rsp_rdata),
    .host_ready    (host_ready),
    .host_rdata    (host_rdata),
    .host_err      (host_err)
  );

  logic [WA_W-1:0] word_addr;
  assign word_addr = host_addr[ADDR_W-1:2];

  // R5: a request only begins while the go flag is set
  assert_go_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_valid) |-> cmd_q.go);

  // R2: a data-window access with go set raises a request next cycle
  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_xact |=> cfg_req_valid);

  // R8: unrelated offsets never have a request in flight
  assert_other_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && (word_addr != DATA_OFFSET[ADDR_W-1:2])) |-> !cfg_req_valid);

endmodule

// File: tb/test_cfg_access_port.sv
`timescale 1ns/1ps
module test_cfg_access_port;

  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, host_err;
  logic [31:0] host_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic [7:0]  cfg_req_bus;
  logic [4:0]  cfg_req_dev;
  logic [2:0]  cfg_req_fn;
  logic [5:0]  cfg_req_dreg;
  logic [3:0]  cfg_req_be;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  cfg_access_port #(.ADDR_W(8), .CMD_OFFSET(8'h28), .TIMEOUT(TMO)) i_cfg_access_port (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_err(host_err),
    .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
    .cfg_req_bus(cfg_req_bus), .cfg_req_dev(cfg_req_dev), .cfg_req_fn(cfg_req_fn),
    .cfg_req_dreg(cfg_req_dreg), .cfg_req_be(cfg_req_be), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // target model: dword store indexed by register number
  logic [31:0] mem [64];
  int          lat = 2;
  bit          silent = 0;
  int          req_seen = 0;
  logic [7:0]  last_bus;
  logic [4:0]  last_dev;
  logic [2:0]  last_fn;
  logic [5:0]  last_dreg;
  logic [3:0]  last_be;
  logic        last_wr;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  initial begin
    int  wcnt;
    bit  prev;
    wcnt = 0;
    prev = 0;
    for (int i = 0; i < 64; i++) mem[i] = {16'hC0DE, 8'(i), ~8'(i)};
    forever begin
      @(negedge clk);
      if (cfg_rsp_valid) begin
        cfg_rsp_valid = 1'b0;
        wcnt = 0;
      end else if (cfg_req_valid) begin
        wcnt++;
        if (!silent && wcnt >= lat) begin
          last_bus = cfg_req_bus; last_dev = cfg_req_dev; last_fn = cfg_req_fn;
          last_dreg = cfg_req_dreg; last_be = cfg_req_be; last_wr = cfg_req_write;
          if (cfg_req_write) mem[cfg_req_dreg] = merge(mem[cfg_req_dreg], cfg_req_wdata, cfg_req_be);
          cfg_rsp_rdata = mem[cfg_req_dreg];
          cfg_rsp_valid = 1'b1;
        end
      end else begin
        wcnt = 0;
      end
      if (cfg_req_valid && !prev) req_seen++;
      prev = cfg_req_valid;
    end
  end

  task automatic access(input logic we, input logic [7:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er,
                        output int cyc);
    @(negedge clk);
    host_valid = 1'b1; host_write = we; host_addr = addr; host_be = be; host_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!host_ready && cyc < 1000);
    rd = host_rdata;
    er = host_err;
    host_valid = 1'b0;
    host_write = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [7:0]  off;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        txn;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 8'h28, 4'hF, 32'hFF122B13, 32'h0,        1'b0}, // R1 junk in reserved bits
    '{1'b0, 8'h28, 4'hF, 32'h0,        32'h80122B10, 1'b0}, // R1 readback cleaned
    '{1'b1, 8'h2C, 4'hF, 32'h11223344, 32'h0,        1'b1}, // R2 R3 full write
    '{1'b0, 8'h2C, 4'hF, 32'h0,        32'h11223344, 1'b1}, // R4 full read
    '{1'b1, 8'h2E, 4'h4, 32'h00AA0000, 32'h0,        1'b1}, // R3 byte lane 2
    '{1'b0, 8'h2C, 4'hF, 32'h0,        32'h11AA3344, 1'b1}, // R3 merged
    '{1'b1, 8'h2E, 4'hC, 32'hBEEF0000, 32'h0,        1'b1}, // R3 upper halfword
    '{1'b0, 8'h2C, 4'hF, 32'h0,        32'hBEEF3344, 1'b1}, // R3 merged
    '{1'b0, 8'h30, 4'hF, 32'h0,        32'h0,        1'b0}, // R8 unrelated read
    '{1'b1, 8'h24, 4'hF, 32'h12345678, 32'h0,        1'b0}, // R8 unrelated write
    '{1'b1, 8'h28, 4'h1, 32'hFFFFFF23, 32'h0,        1'b0}, // R1 byte 0 only
    '{1'b0, 8'h28, 4'hF, 32'h0,        32'h80122B20, 1'b0}, // R1 dreg now 8
    '{1'b0, 8'h2C, 4'hF, 32'h0,        32'hC0DE08F7, 1'b1}  // R2 reads dword 8
  };

  initial begin
    logic [31:0] rd;
    logic        er;
    int          cyc, seen0;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 ready low in reset", 32'(host_ready), 32'h0);
    chk("R9 no request in reset", 32'(cfg_req_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 no request after reset", 32'(cfg_req_valid), 32'h0);
    access(1'b0, 8'h28, 4'hF, 32'h0, rd, er, cyc);
    chk("R9 command reads zero", rd, 32'h0);

    // table walk
    for (int v = 0; v < 13; v++) begin
      seen0 = req_seen;
      access(VECS[v].we, VECS[v].off, VECS[v].be, VECS[v].wd, rd, er, cyc);
      chk($sformatf("R2 R8 request count vec %0d", v), 32'(req_seen - seen0), 32'(VECS[v].txn));
      if (!VECS[v].we) chk($sformatf("R4 read data vec %0d", v), rd, VECS[v].exp);
      chk($sformatf("R7 no error vec %0d", v), 32'(er), 32'h0);
      if (VECS[v].txn) begin
        chk($sformatf("R3 R4 target be vec %0d", v), 32'(last_be), VECS[v].we ? 32'(VECS[v].be) : 32'hF);
        chk($sformatf("R2 direction vec %0d", v), 32'(last_wr), 32'(VECS[v].we));
      end
      if (v == 2) begin
        chk("R2 bus field", 32'(last_bus), 32'h12);
        chk("R2 device field", 32'(last_dev), 32'h5);
        chk("R2 function field", 32'(last_fn), 32'h3);
        chk("R2 dword field", 32'(last_dreg), 32'h4);
      end
      if (v == 12) chk("R2 dword field after byte update", 32'(last_dreg), 32'h8);
    end
    chk("R8 write to other offset left store intact", mem[9], 32'hC0DE09F6);

    // R5 go flag clear
    access(1'b1, 8'h28, 4'hF, 32'h00122B10, rd, er, cyc);
    seen0 = req_seen;
    access(1'b0, 8'h2C, 4'hF, 32'h0, rd, er, cyc);
    chk("R5 disabled read data", rd, 32'hFFFFFFFF);
    chk("R5 disabled read no error", 32'(er), 32'h0);
    access(1'b1, 8'h2C, 4'hF, 32'hDEADBEEF, rd, er, cyc);
    chk("R5 disabled accesses issue nothing", 32'(req_seen - seen0), 32'h0);
    access(1'b1, 8'h28, 4'hF, 32'h80122B10, rd, er, cyc);
    access(1'b0, 8'h2C, 4'hF, 32'h0, rd, er, cyc);
    chk("R5 target dword untouched by disabled write", rd, 32'hBEEF3344);

    // R4 sub-word read at offset 1: full dword, lane picked by shift
    access(1'b0, 8'h2D, 4'h2, 32'h0, rd, er, cyc);
    chk("R4 sub-word read returns full dword", rd, 32'hBEEF3344);
    chk("R4 byte at offset 1", (rd >> 8) & 32'hFF, 32'h33);
    chk("R4 read be full on sub-word", 32'(last_be), 32'hF);

    // R6 slow target stalls the host
    lat = 7;
    access(1'b0, 8'h2C, 4'hF, 32'h0, rd, er, cyc);
    chk("R6 stall covers target latency", 32'(cyc >= 8), 32'h1);
    chk("R6 data after slow response", rd, 32'hBEEF3344);
    lat = 2;

    // R7 silent target
    silent = 1;
    seen0 = req_seen;
    access(1'b0, 8'h2C, 4'hF, 32'h0, rd, er, cyc);
    chk("R7 timeout error flag", 32'(er), 32'h1);
    chk("R7 timeout read data", rd, 32'hFFFFFFFF);
    chk("R7 stall lasts the timeout", 32'(cyc >= TMO), 32'h1);
    chk("R7 single request issued", 32'(req_seen - seen0), 32'h1);
    chk("R7 request withdrawn", 32'(cfg_req_valid), 32'h0);
    silent = 0;
    repeat (2) @(negedge clk);
    access(1'b0, 8'h2C, 4'hF, 32'h0, rd, er, cyc);
    chk("R7 recovery no error", 32'(er), 32'h0);
    chk("R7 recovery data", rd, 32'hBEEF3344);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule